// File: doc/BRIEF.md
# Serial-Shift Timer Channel

This block is one programmable timer channel. It produces a timer output and a shift clock for a companion shift-register engine. The shift clock is the timer output itself. A two-bit mode input selects the operation. Three codes are counting modes: a single 16-bit counter, a dual 8-bit counter that emits a bounded number of bit edges, and a dual 8-bit pulse-width generator. The fourth code switches the channel off. A two-bit output code sets the level the output takes when the channel starts. Its upper bit also decides whether a timer reset forces that level again. A decrement select picks the decrement source: either every module clock cycle, or every edge of a trigger input, rising or falling.

The channel is built around a three-state controller:
- `ST_OFF`: the channel is idle.
- `ST_RUN`: the channel is counting.
- `ST_DONE`: the channel has completed a finite bit sequence and is holding.

The transitions are:
- OFF→RUN on enable (start).
- RUN→RUN on a timer reset (reload).
- RUN→DONE when the bit sequence ends (finish).
- DONE→RUN on a timer reset (restart).
- Any state→OFF when the enable condition drops (stop).

Several channels sit side by side. A channel can be made to run only while the channel below it is active. A channel whose index parameter is a multiple of four has no such neighbour, so it ignores that selection.

Top module: `sst_timer`

## Requirements
- R1: While `mode_i` is 00 (or the enable condition is false), the count is held and, one clock later, `tmr_out_o` equals the enable level and `active_o` is 0. The enable level is 1 when `out_cfg_i[0]`=0 and 0 when `out_cfg_i[0]`=1.
- R2: At the first clock edge with an enabling mode while in `ST_OFF`, the channel enters `ST_RUN`: `active_o`=1 and `tmr_out_o` is the enable level. `count_o` loads `cmp_i` in modes 11 and 01, and loads `{8'h00, cmp_i[7:0]}` in mode 10.
- R3: In mode 11 (16-bit), a decrement with `count_o`=0 toggles the output and reloads `cmp_i`. Any other decrement subtracts one, so the output toggles every `cmp_i`+1 decrements.
- R4: In mode 01 (bit mode), the low byte counts down from `cmp_i[7:0]` and the high byte holds the number of remaining toggles. When the low byte expires with a nonzero high byte, the output toggles, the high byte decrements and the low byte reloads. When it expires with a zero high byte, the output returns to the enable level and the channel enters `ST_DONE` and holds.
- R5: In mode 10 (pulse width), the output stays at the enable level for `cmp_i[7:0]`+1 decrements, then at the opposite level for `cmp_i[15:8]`+1 decrements, repeating.
- R6: With `dec_sel_i`=0, the counter decrements on every clock cycle and `trigger_i` has no effect.
- R7: With `dec_sel_i`=1, each change of `trigger_i` (rising or falling) gives exactly one decrement, applied at the second clock edge after the change. Without a change the count holds.
- R8: A timer reset (`timer_rst_i`=1) with `out_cfg_i[1]`=1 reloads the count and drives the output to the enable level at the next edge.
- R9: A timer reset with `out_cfg_i[1]`=0 reloads the count and leaves the output unchanged. In `ST_DONE`, a timer reset restarts counting in `ST_RUN`.
- R10: `shift_clk_o` always equals `tmr_out_o`.
- R11: When `CH_IDX` is not a multiple of 4 and `chain_en_i`=1, the channel is enabled only while `prev_act_i`=1. When `CH_IDX` is a multiple of 4, `chain_en_i` and `prev_act_i` are ignored.
- R12: While `rst_n` is low, `tmr_out_o`=0, `count_o`=0 and `active_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 off, 01 bit mode, 10 pulse width, 11 16-bit |
| out_cfg_i | input | 2 | Bit 0: enable level is low; bit 1: timer reset forces the enable level |
| dec_sel_i | input | 1 | 0: decrement each clock; 1: decrement on trigger edges |
| cmp_i | input | 16 | Reload value (high byte and low byte in the 8-bit modes) |
| trigger_i | input | 1 | Trigger used as decrement source |
| timer_rst_i | input | 1 | Timer reset: reload and optionally re-level the output |
| chain_en_i | input | 1 | Run only while the neighbouring channel is active |
| prev_act_i | input | 1 | Active flag of the neighbouring channel |
| tmr_out_o | output | 1 | Timer output |
| shift_clk_o | output | 1 | Shift clock for the shift engine |
| active_o | output | 1 | Channel is not in `ST_OFF` |
| count_o | output | 16 | Current counter value |

## Verification
The bench sweeps all four output codes across all three counting modes and five reload values. Values with a zero byte, a one and a byte-straddling count separate the 16-bit borrow path from the split 8-bit counters, and separate the two phase lengths of pulse-width mode. The trigger is toggled during clock-decrement runs to show it is ignored. A separate trigger-decrement run checks the two-edge latency and the hold on a quiet trigger. Timer resets issued at each output code distinguish a forced level from a kept level, and one reset is issued in the done state. Two instances with different index parameters, fed identical chaining inputs, tell the gated channel from the one that ignores the selection.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_BAUD = 2'b01,
        MD_PWM  = 2'b10,
        MD_WIDE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_DONE
    } state_e;

endpackage

// File: rtl/sst_trig_edge.sv
module sst_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic edge_o
);
    logic trig_q;
    logic trig_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            trig_d <= 1'b0;
        end else begin
            trig_q <= trigger_i;
            trig_d <= trig_q;
        end
    end

    // One-cycle pulse for every level change of the trigger
    assign edge_o = trig_q ^ trig_d;
endmodule

// File: rtl/sst_enable_gate.sv
module sst_enable_gate #(
    parameter int CH_IDX = 0
) (
    input  logic [1:0] mode_i,
    input  logic       chain_en_i,
    input  logic       prev_act_i,
    output logic       run_ok_o
);
    localparam bit HAS_PREV = (CH_IDX % 4) != 0;

    generate
        if (HAS_PREV) begin : g_chained
            assign run_ok_o = (mode_i != 2'b00) && (!chain_en_i || prev_act_i);
        end else begin : g_first
            logic unused_chain;
            assign unused_chain = chain_en_i ^ prev_act_i;
            assign run_ok_o     = (mode_i != 2'b00);
        end
    endgenerate
endmodule

// File: rtl/sst_count_path.sv
module sst_count_path
    import sst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cur_out_i,
    input  logic             en_lvl_i,
    output logic [CNT_W-1:0] load_val_o,
    output logic [CNT_W-1:0] dec_val_o,
    output logic             wrap_o,
    output logic             finish_o
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE_W = 1;
    localparam logic [HALF-1:0]  ONE_H = 1;
    localparam logic [HALF-1:0]  ZERO_H = '0;

    logic [HALF-1:0] lo, hi, cmp_lo, cmp_hi, pwm_reload;
    logic            lo_zero, hi_zero, all_zero;

    assign lo       = cnt_i[HALF-1:0];
    assign hi       = cnt_i[CNT_W-1:HALF];
    assign cmp_lo   = cmp_i[HALF-1:0];
    assign cmp_hi   = cmp_i[CNT_W-1:HALF];
    assign lo_zero  = (lo == ZERO_H);
    assign hi_zero  = (hi == ZERO_H);
    assign all_zero = lo_zero && hi_zero;
    // Next phase after a wrap is the inverse of the current level
    assign pwm_reload = ((~cur_out_i) == en_lvl_i) ? cmp_lo : cmp_hi;

    always_comb begin
        wrap_o     = 1'b0;
        finish_o   = 1'b0;
        dec_val_o  = cnt_i;
        load_val_o = cmp_i;
        unique case (mode_e'(mode_i))
            MD_WIDE: begin
                wrap_o    = all_zero;
                dec_val_o = all_zero ? cmp_i : (cnt_i - ONE_W);
            end
            MD_BAUD: begin
                wrap_o   = lo_zero && !hi_zero;
                finish_o = lo_zero && hi_zero;
                if (!lo_zero)
                    dec_val_o = {hi, lo - ONE_H};
                else if (!hi_zero)
                    dec_val_o = {hi - ONE_H, cmp_lo};
                else
                    dec_val_o = cnt_i;
            end
            MD_PWM: begin
                load_val_o = {ZERO_H, cmp_lo};
                wrap_o     = lo_zero;
                dec_val_o  = lo_zero ? {ZERO_H, pwm_reload} : {ZERO_H, lo - ONE_H};
            end
            MD_OFF: begin
                dec_val_o = cnt_i;
            end
        endcase
    end
endmodule

// File: rtl/sst_timer.sv
module sst_timer
    import sst_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CH_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       out_cfg_i,
    input  logic             dec_sel_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             trigger_i,
    input  logic             timer_rst_i,
    input  logic             chain_en_i,
    input  logic             prev_act_i,
    output logic             tmr_out_o,
    output logic             shift_clk_o,
    output logic             active_o,
    output logic [CNT_W-1:0] count_o
);
    state_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic             run_ok, trig_edge, dec_en, en_lvl, keep_lvl;
    logic [CNT_W-1:0] load_val, dec_val;
    logic             wrap, finish;

    assign en_lvl   = ~out_cfg_i[0];
    assign keep_lvl = ~out_cfg_i[1];

    sst_trig_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (trigger_i),
        .edge_o    (trig_edge)
    );

    sst_enable_gate #(.CH_IDX(CH_IDX)) u_gate (
        .mode_i     (mode_i),
        .chain_en_i (chain_en_i),
        .prev_act_i (prev_act_i),
        .run_ok_o   (run_ok)
    );

    sst_count_path #(.CNT_W(CNT_W)) u_path (
        .mode_i     (mode_i),
        .cnt_i      (cnt_q),
        .cmp_i      (cmp_i),
        .cur_out_i  (out_q),
        .en_lvl_i   (en_lvl),
        .load_val_o (load_val),
        .dec_val_o  (dec_val),
        .wrap_o     (wrap),
        .finish_o   (finish)
    );

    assign dec_en = dec_sel_i ? trig_edge : 1'b1;

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (run_ok) st_d = ST_RUN;                 // start
            end
            ST_RUN: begin
                if (!run_ok)                 st_d = ST_OFF;  // stop
                else if (timer_rst_i)        st_d = ST_RUN;  // reload
                else if (dec_en && finish)   st_d = ST_DONE; // finish
            end
            ST_DONE: begin
                if (!run_ok)           st_d = ST_OFF;        // stop
                else if (timer_rst_i)  st_d = ST_RUN;        // restart
            end
            default: st_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Counter and output level per state
    always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        if (!run_ok) begin
            out_d = en_lvl;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    cnt_d = load_val;
                    out_d = en_lvl;
                end
                ST_RUN: begin
                    if (timer_rst_i) begin
                        cnt_d = load_val;
                        if (!keep_lvl) out_d = en_lvl;
                    end else if (dec_en) begin
                        if (finish) begin
                            out_d = en_lvl;
                        end else begin
                            cnt_d = dec_val;
                            if (wrap) out_d = ~out_q;
                        end
                    end
                end
                ST_DONE: begin
                    if (timer_rst_i) begin
                        cnt_d = load_val;
                        if (!keep_lvl) out_d = en_lvl;
                    end
                end
                default: begin
                    cnt_d = cnt_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    assign tmr_out_o   = out_q;
    assign shift_clk_o = out_q;
    assign active_o    = (st_q != ST_OFF);
    assign count_o     = cnt_q;
endmodule

// File: rtl/sst_timer_chk.sv
module sst_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [1:0]       out_cfg_i,
    input logic             dec_sel_i,
    input logic             trigger_i,
    input logic             timer_rst_i,
    input logic             chain_en_i,
    input logic             tmr_out_o,
    input logic             active_o,
    input logic [CNT_W-1:0] count_o
);
    logic [1:0] cyc;
    logic       cyc_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end
    assign cyc_ok = (cyc >= 2'd2);

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> (count_o == $past(count_o))); // R1

    AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> (!active_o && tmr_out_o == !$past(out_cfg_i[0]))); // R1

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && mode_i != 2'b00 && !chain_en_i)
        |=> (active_o && tmr_out_o == !$past(out_cfg_i[0]))); // R2

    AST_TRIG_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && active_o && mode_i != 2'b00 && !chain_en_i && dec_sel_i && !timer_rst_i
         && ($past(trigger_i) == $past(trigger_i, 2)))
        |=> $stable(count_o)); // R7

    AST_RST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_rst_i && out_cfg_i[1]) |=> (tmr_out_o == !$past(out_cfg_i[0]))); // R8

    AST_RST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && timer_rst_i && !out_cfg_i[1] && mode_i != 2'b00 && !chain_en_i)
        |=> $stable(tmr_out_o)); // R9
endmodule

bind sst_timer sst_timer_chk #(.CNT_W(CNT_W)) u_sst_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .out_cfg_i   (out_cfg_i),
    .dec_sel_i   (dec_sel_i),
    .trigger_i   (trigger_i),
    .timer_rst_i (timer_rst_i),
    .chain_en_i  (chain_en_i),
    .tmr_out_o   (tmr_out_o),
    .active_o    (active_o),
    .count_o     (count_o)
);

// File: tb/test_sst_timer.sv
module test_sst_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode, out_cfg;
    logic        dec_sel, trigger, timer_rst, chain_en, prev_act;
    logic [15:0] cmp;
    logic        tmr_out, shift_clk, active;
    logic [15:0] count;
    logic        tmr_out1, shift_clk1, active1;
    logic [15:0] count1;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sst_timer #(.CNT_W(16), .CH_IDX(0)) i_sst_timer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .out_cfg_i(out_cfg),
        .dec_sel_i(dec_sel), .cmp_i(cmp), .trigger_i(trigger),
        .timer_rst_i(timer_rst), .chain_en_i(chain_en), .prev_act_i(prev_act),
        .tmr_out_o(tmr_out), .shift_clk_o(shift_clk), .active_o(active), .count_o(count)
    );

    sst_timer #(.CNT_W(16), .CH_IDX(1)) i_sst_timer_c1 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .out_cfg_i(out_cfg),
        .dec_sel_i(dec_sel), .cmp_i(cmp), .trigger_i(trigger),
        .timer_rst_i(timer_rst), .chain_en_i(chain_en), .prev_act_i(prev_act),
        .tmr_out_o(tmr_out1), .shift_clk_o(shift_clk1), .active_o(active1), .count_o(count1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_out(input int md, input logic en, input int c, input int k);
        int lo = c & 255;
        int hi = c >> 8;
        int p, t, r;
        if (md == 3) begin
            p = c + 1;
            return en ^ logic'((k / p) % 2);
        end else if (md == 1) begin
            p = lo + 1;
            if (k >= (hi + 1) * p) return en;
            return en ^ logic'((k / p) % 2);
        end else begin
            t = lo + hi + 2;
            r = k % t;
            return (r < lo + 1) ? en : ~en;
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cmps[5] = '{16'h0000, 16'h0001, 16'h0102, 16'h0203, 16'h0300};
        logic en;
        logic [15:0] held;
        rst_n = 1'b0; mode = 2'b00; out_cfg = 2'b00; dec_sel = 1'b0; cmp = '0;
        trigger = 1'b0; timer_rst = 1'b0; chain_en = 1'b0; prev_act = 1'b0;
        step(3);
        // R12 reset state
        chk(tmr_out == 1'b0, "R12 out", int'(tmr_out), 0);
        chk(count == 16'd0, "R12 count", int'(count), 0);
        chk(active == 1'b0, "R12 active", int'(active), 0);
        rst_n = 1'b1;
        step(2);

        // Sweep: modes x output codes x reload values, clock decrement (R3 R4 R5 R6)
        for (int md = 1; md <= 3; md++) begin
            for (int cf = 0; cf < 4; cf++) begin
                for (int ci = 0; ci < 5; ci++) begin
                    out_cfg = 2'(cf); cmp = 16'(cmps[ci]); en = ~out_cfg[0];
                    step(1);
                    chk(tmr_out == en && active == 1'b0, "R1 off level", int'(tmr_out), int'(en));
                    mode = 2'(md);
                    step(1);
                    chk(active == 1'b1, "R2 active", int'(active), 1);
                    chk(tmr_out == en, "R2 start level", int'(tmr_out), int'(en));
                    chk(count == ((md == 2) ? (cmp & 16'h00ff) : cmp), "R2 load",
                        int'(count), (md == 2) ? int'(cmp & 16'h00ff) : int'(cmp));
                    for (int k = 1; k <= 40; k++) begin
                        trigger = ~trigger; // R6 trigger ignored with clock decrement
                        step(1);
                        chk(tmr_out == exp_out(md, en, int'(cmp), k),
                            (md == 3) ? "R3 wide out" : (md == 1) ? "R4 bit out" : "R5 pwm out",
                            int'(tmr_out), int'(exp_out(md, en, int'(cmp), k)));
                        chk(shift_clk == tmr_out, "R10 shift clock", int'(shift_clk), int'(tmr_out));
                        if (md == 3)
                            chk(int'(count) == int'(cmp) - (k % (int'(cmp) + 1)), "R6 wide count",
                                int'(count), int'(cmp) - (k % (int'(cmp) + 1)));
                    end
                    held = count;
                    mode = 2'b00;
                    step(1);
                    chk(count == held, "R1 hold", int'(count), int'(held));
                    chk(active == 1'b0, "R1 inactive", int'(active), 0);
                    step(2);
                    chk(count == held, "R1 hold long", int'(count), int'(held));
                end
            end
        end

        // Trigger-edge decrement (R7)
        out_cfg = 2'b00; cmp = 16'd2; dec_sel = 1'b1;
        step(3);
        mode = 2'b11;
        step(1);
        step(3);
        chk(count == 16'd2, "R7 quiet hold", int'(count), 2);
        for (int n = 1; n <= 8; n++) begin
            trigger = ~trigger;
            step(1);
            chk(int'(count) == 2 - ((n - 1) % 3), "R7 latency", int'(count), 2 - ((n - 1) % 3));
            step(1);
            chk(int'(count) == 2 - (n % 3), "R7 edge count", int'(count), 2 - (n % 3));
            chk(tmr_out == (1'b1 ^ logic'((n / 3) % 2)), "R7 edge out",
                int'(tmr_out), int'(1'b1 ^ logic'((n / 3) % 2)));
            step(1);
        end
        mode = 2'b00; dec_sel = 1'b0;
        step(2);

        // Timer reset with each output code (R8 R9)
        for (int cf = 0; cf < 4; cf++) begin
            out_cfg = 2'(cf); cmp = 16'd3; en = ~out_cfg[0];
            step(1);
            mode = 2'b11;
            step(1);
            step(5);
            chk(tmr_out == ~en && count == 16'd2, "R3 pre-reset", int'(count), 2);
            timer_rst = 1'b1;
            step(1);
            timer_rst = 1'b0;
            chk(count == 16'd3, out_cfg[1] ? "R8 reload" : "R9 reload", int'(count), 3);
            chk(tmr_out == (out_cfg[1] ? en : ~en), out_cfg[1] ? "R8 forced level" : "R9 kept level",
                int'(tmr_out), int'(out_cfg[1] ? en : ~en));
            step(4);
            chk(tmr_out == (out_cfg[1] ? ~en : en), out_cfg[1] ? "R8 after" : "R9 after",
                int'(tmr_out), int'(out_cfg[1] ? ~en : en));
            mode = 2'b00;
            step(2);
        end

        // Done state and restart (R4 R9)
        out_cfg = 2'b01; cmp = 16'h0101; en = 1'b0;
        step(1);
        mode = 2'b01;
        step(1);
        step(6);
        held = count;
        chk(active == 1'b1 && tmr_out == en, "R4 done level", int'(tmr_out), int'(en));
        step(3);
        chk(count == held && tmr_out == en, "R4 done hold", int'(count), int'(held));
        timer_rst = 1'b1;
        step(1);
        timer_rst = 1'b0;
        chk(count == 16'h0101, "R9 restart reload", int'(count), 16'h0101);
        step(2);
        chk(tmr_out == ~en, "R9 restart toggles", int'(tmr_out), int'(~en));
        mode = 2'b00;
        step(2);

        // Chained enable (R11)
        out_cfg = 2'b00; cmp = 16'd1; chain_en = 1'b1; prev_act = 1'b0;
        mode = 2'b11;
        step(1);
        chk(active == 1'b1, "R11 index0 ignores chain", int'(active), 1);
        chk(active1 == 1'b0, "R11 index1 gated", int'(active1), 0);
        prev_act = 1'b1;
        step(1);
        chk(active1 == 1'b1, "R11 index1 runs", int'(active1), 1);
        prev_act = 1'b0;
        step(1);
        chk(active1 == 1'b0, "R11 index1 stops", int'(active1), 0);
        chk(active == 1'b1, "R11 index0 keeps", int'(active), 1);
        chain_en = 1'b0;
        step(1);
        chk(active1 == 1'b1, "R11 chain off", int'(active1), 1);
        mode = 2'b00;
        step(2);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule